// File: doc/BRIEF.md
# Power-Up Supply Sequencer

This block brings a group of regulator enables up in a fixed order after a cold-start request. On the request it first holds every supply off for an 8 ms initial interval. During that interval it drives an active-discharge control, so that the switching and linear outputs bleed down and the core logic settles. It then steps through 2 ms time slots. Each slot is cut into four 0.5 ms sub-steps, and at most one supply is switched on in any sub-step, which spreads the inrush current of a busy slot. A 2-bit startup code, latched when the request is accepted, selects which slot and sub-step each supply uses. The latched code is presented on a status output.

The raw under-voltage flag is forced inactive while the discharge interval and the slots are running. Once the last used slot has ended, the block raises a done flag, releases the mask and keeps the enables latched. The power-gate outputs are never touched by the sequencer; only a software write sets them. All timing comes from a single-cycle tick input, one pulse every 0.5 ms, so the initial interval is 16 ticks and a slot is 4 ticks.

Top module: `pwr_seq`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge), `sup_en`, `gate_en`, `discharge`, `done` and `cfg_status` are all zero and the block is idle.
- R2: After a start request accepted in idle, `discharge` is 1 and `sup_en` is all zero until the 16th tick after the request. `discharge` falls at the edge that samples that tick.
- R3: A supply assigned to slot s (1..7) and sub-step u (0..3) turns on at the edge sampling tick number 16 + 4·(s−1) + u after the request, and stays on afterwards. The assignments, written as supply:slot.sub, are as follows. Code 0 gives 0:1.0, 1:1.1, 2:2.0, 3:3.0, 4:3.2, with supply 5 unused. Code 1 gives 0:1.0, 1:2.0, 2:2.1, 3:2.2, 4:4.0, 5:4.3. Code 2 gives 0:1.0, 1:1.1, with supplies 2–5 unused. Code 3 gives 0:1.0, 1:1.1, 2:1.2, 3:1.3, 4:2.0, 5:2.1.
- R4: No clock edge turns on more than one supply.
- R5: A supply whose slot value is 0 (unused) for the latched code is never turned on by the sequencer.
- R6: `uv_masked` is 0 whenever `discharge` is 1 or slots are running. In idle and after done it equals `uv_raw`.
- R7: `done` rises at the edge sampling tick 16 + 4·S, where S is the highest slot used by the code. After that, `done` and `sup_en` stay constant until reset.
- R8: A start request while the sequence is running or done is ignored: the timing, the enables and `cfg_status` are unchanged.
- R9: `gate_en` changes only on a clock edge with `sw_gate_we` high, where it takes `sw_gate_wdata`. The sequence never changes it.
- R10: `cfg_status` shows the `cfg_code` value captured when the start request was accepted. Later changes of `cfg_code` do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Cold-start request, one cycle |
| cfg_code | input | 2 | Startup configuration code |
| uv_raw | input | 1 | Raw under-voltage flag |
| tick | input | 1 | Single-cycle 0.5 ms time base pulse |
| sw_gate_we | input | 1 | Software write strobe for power gates |
| sw_gate_wdata | input | N_GATE | Power-gate value written by software |
| sup_en | output | 6 | Supply enables |
| gate_en | output | N_GATE | Power-gate driver enables |
| discharge | output | 1 | Active output discharge control |
| uv_masked | output | 1 | Under-voltage flag after masking |
| done | output | 1 | Sequence finished |
| cfg_status | output | 2 | Latched startup code |

## Verification
`sup_en`, `discharge` and `done` are registered. Each one changes at the very edge that samples the qualifying tick. `uv_masked` follows the state combinationally, so it also settles right after that edge. The bench drives each tick for one cycle from a falling edge and compares all outputs at the next falling edge, half a cycle after the capturing edge. It works out, from the slot table and the formula in R3, the cumulative enable vector expected after every tick. Restart requests and code changes are inserted between ticks, so any disturbance would show up at the next comparison.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    localparam int N_SUP  = 6;
    localparam int CFG_W  = 2;
    localparam int SLOT_W = 3;
    localparam int SUB_W  = 2;
    localparam int SUBS   = 1 << SUB_W;

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [SUB_W-1:0]  sub;
    } seq_pos_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DISCH = 2'd1,
        ST_SLOTS = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_t;

    function automatic seq_pos_t mk_pos(input int s, input int u);
        seq_pos_t r;
        r.slot = SLOT_W'(s);
        r.sub  = SUB_W'(u);
        return r;
    endfunction

    // slot 0 marks a supply the sequencer leaves off
    function automatic seq_pos_t slot_map(input logic [CFG_W-1:0] cfg, input int idx);
        seq_pos_t r;
        r = mk_pos(0, 0);
        case (cfg)
            2'd0: case (idx)
                0: r = mk_pos(1, 0);
                1: r = mk_pos(1, 1);
                2: r = mk_pos(2, 0);
                3: r = mk_pos(3, 0);
                4: r = mk_pos(3, 2);
                default: r = mk_pos(0, 0);
            endcase
            2'd1: case (idx)
                0: r = mk_pos(1, 0);
                1: r = mk_pos(2, 0);
                2: r = mk_pos(2, 1);
                3: r = mk_pos(2, 2);
                4: r = mk_pos(4, 0);
                5: r = mk_pos(4, 3);
                default: r = mk_pos(0, 0);
            endcase
            2'd2: case (idx)
                0: r = mk_pos(1, 0);
                1: r = mk_pos(1, 1);
                default: r = mk_pos(0, 0);
            endcase
            default: case (idx)
                0: r = mk_pos(1, 0);
                1: r = mk_pos(1, 1);
                2: r = mk_pos(1, 2);
                3: r = mk_pos(1, 3);
                4: r = mk_pos(2, 0);
                5: r = mk_pos(2, 1);
                default: r = mk_pos(0, 0);
            endcase
        endcase
        return r;
    endfunction

    function automatic logic [SLOT_W-1:0] last_slot(input logic [CFG_W-1:0] cfg);
        logic [SLOT_W-1:0] m;
        seq_pos_t p;
        m = '0;
        for (int i = 0; i < N_SUP; i++) begin
            p = slot_map(cfg, i);
            if (p.slot > m) m = p.slot;
        end
        return m;
    endfunction

endpackage

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/pwr_seq_match.sv
module pwr_seq_match
    import pwr_seq_pkg::*;
(
    input  logic [CFG_W-1:0] cfg,
    input  seq_pos_t         pos,
    output logic [N_SUP-1:0] hit
);
    for (genvar i = 0; i < N_SUP; i++) begin : g_sup
        seq_pos_t ent;
        always_comb begin
            ent    = slot_map(cfg, i);
            hit[i] = (ent.slot != '0) && (ent.slot == pos.slot) && (ent.sub == pos.sub);
        end
    end
endmodule

// File: rtl/pwr_seq.sv
module pwr_seq
    import pwr_seq_pkg::*;
#(
    parameter int DELAY_TICKS = 16,
    parameter int N_GATE      = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_req,
    input  logic [CFG_W-1:0]  cfg_code,
    input  logic              uv_raw,
    input  logic              tick,
    input  logic              sw_gate_we,
    input  logic [N_GATE-1:0] sw_gate_wdata,
    output logic [N_SUP-1:0]  sup_en,
    output logic [N_GATE-1:0] gate_en,
    output logic              discharge,
    output logic              uv_masked,
    output logic              done,
    output logic [CFG_W-1:0]  cfg_status
);
    localparam int MAX_POS = (1 << SLOT_W) * SUBS;
    localparam int SPAN    = (DELAY_TICKS > MAX_POS) ? DELAY_TICKS : MAX_POS;
    localparam int CNT_W   = $clog2(SPAN) + 1;

    seq_state_t        st;
    logic [CFG_W-1:0]  cfg_q;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  npos;
    logic [CNT_W-1:0]  last_pos;
    logic [CNT_W-SUB_W-1:0] npos_hi;
    seq_pos_t          pos;
    logic [N_SUP-1:0]  hit;
    logic              accept, delay_end, slot_step, seq_end, load_en, running;

    always_comb begin
        accept    = (st == ST_IDLE) && start_req;
        delay_end = (st == ST_DISCH) && tick && (cnt == CNT_W'(DELAY_TICKS - 1));
        last_pos  = CNT_W'(int'(last_slot(cfg_q)) * SUBS - 1);
        slot_step = (st == ST_SLOTS) && tick;
        seq_end   = slot_step && (cnt == last_pos);
        load_en   = delay_end || (slot_step && !seq_end);
        npos      = delay_end ? '0 : cnt + CNT_W'(1);
        npos_hi   = npos[CNT_W-1:SUB_W];
        pos.sub   = npos[SUB_W-1:0];
        pos.slot  = SLOT_W'(npos_hi) + SLOT_W'(1);
        running   = (st == ST_DISCH) || (st == ST_SLOTS);
    end

    pwr_seq_timer #(.CNT_W(CNT_W)) timer_i (
        .clk  (clk),
        .rst  (rst),
        .clr  (accept || delay_end),
        .tick (tick),
        .cnt  (cnt)
    );

    pwr_seq_match match_i (
        .cfg (cfg_q),
        .pos (pos),
        .hit (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            cfg_q <= '0;
        end else begin
            case (st)
                ST_IDLE:  if (start_req) begin
                              st    <= ST_DISCH;
                              cfg_q <= cfg_code;
                          end
                ST_DISCH: if (delay_end) st <= ST_SLOTS;
                ST_SLOTS: if (seq_end)   st <= ST_DONE;
                default:  st <= ST_DONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            sup_en <= '0;
        else if (load_en)
            sup_en <= sup_en | hit;
    end

    always_ff @(posedge clk) begin
        if (rst)
            gate_en <= '0;
        else if (sw_gate_we)
            gate_en <= sw_gate_wdata;
    end

    assign discharge  = (st == ST_DISCH);
    assign done       = (st == ST_DONE);
    assign uv_masked  = uv_raw && !running;
    assign cfg_status = cfg_q;

    // R2
    disch_off_chk: assert property (@(posedge clk) disable iff (rst)
        discharge |-> (sup_en == '0));

    // R6
    uv_mask_chk: assert property (@(posedge clk) disable iff (rst)
        discharge |-> !uv_masked);

    // R4
    one_rise_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones(sup_en & ~$past(sup_en)) <= 1));

    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (done && $stable(sup_en)));

    // R9
    gate_sw_only_chk: assert property (@(posedge clk) disable iff (rst)
        !sw_gate_we |=> $stable(gate_en));

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE) |=> $stable(cfg_status));

endmodule

// File: tb/pwr_seq_tb.sv
module pwr_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DLY        = 16;
    localparam int NS         = 6;
    localparam int NG         = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b0;
    logic          start_req = 1'b0;
    logic [1:0]    cfg_code = 2'd0;
    logic          uv_raw = 1'b0;
    logic          tick = 1'b0;
    logic          sw_gate_we = 1'b0;
    logic [NG-1:0] sw_gate_wdata = '0;
    logic [NS-1:0] sup_en;
    logic [NG-1:0] gate_en;
    logic          discharge, uv_masked, done;
    logic [1:0]    cfg_status;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_seq #(.DELAY_TICKS(DLY), .N_GATE(NG)) dut_i (
        .clk(clk), .rst(rst), .start_req(start_req), .cfg_code(cfg_code),
        .uv_raw(uv_raw), .tick(tick), .sw_gate_we(sw_gate_we),
        .sw_gate_wdata(sw_gate_wdata), .sup_en(sup_en), .gate_en(gate_en),
        .discharge(discharge), .uv_masked(uv_masked), .done(done),
        .cfg_status(cfg_status)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // slot/sub table from R3; slot 0 = unused
    function automatic int tb_slot(input int c, input int i);
        int t[4][6] = '{'{1,1,2,3,3,0}, '{1,2,2,2,4,4}, '{1,1,0,0,0,0}, '{1,1,1,1,2,2}};
        return t[c][i];
    endfunction
    function automatic int tb_sub(input int c, input int i);
        int t[4][6] = '{'{0,1,0,0,2,0}, '{0,0,1,2,0,3}, '{0,1,0,0,0,0}, '{0,1,2,3,0,1}};
        return t[c][i];
    endfunction
    function automatic int tb_max(input int c);
        int m = 0;
        for (int i = 0; i < NS; i++) if (tb_slot(c, i) > m) m = tb_slot(c, i);
        return m;
    endfunction
    function automatic logic [NS-1:0] tb_exp_en(input int c, input int k);
        logic [NS-1:0] e = '0;
        for (int i = 0; i < NS; i++)
            if (tb_slot(c, i) != 0 && k >= DLY + 4*(tb_slot(c, i)-1) + tb_sub(c, i)) e[i] = 1'b1;
        return e;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; start_req = 1'b0; tick = 1'b0; sw_gate_we = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic pulse_start(input logic [1:0] c);
        @(negedge clk); cfg_code = c; start_req = 1'b1;
        @(negedge clk); start_req = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk(sup_en == '0 && gate_en == '0, "R1 enables", {sup_en, gate_en}, 0);
        chk(!discharge && !done && cfg_status == 2'd0, "R1 flags",
            {discharge, done, cfg_status}, 0);
    endtask

    task automatic t_sequence(input int c, input bit disturb);
        logic [NS-1:0] prev;
        int dk = DLY + 4*tb_max(c);
        do_reset();
        uv_raw = 1'b1;
        pulse_start(2'(c));
        chk(discharge && sup_en == '0, "R2 start", {discharge, sup_en}, {1'b1, 6'd0});
        chk(cfg_status == 2'(c), "R10 latch", cfg_status, c);
        prev = '0;
        for (int k = 1; k <= dk + 2; k++) begin
            if (disturb && (k == 5 || k == DLY + 2 || k == dk + 1)) begin
                pulse_start(2'(c ^ 1));
                chk(cfg_status == 2'(c), "R8 restart ignored", cfg_status, c);
            end
            pulse_tick();
            chk(sup_en == tb_exp_en(c, k), "R3 enables", sup_en, tb_exp_en(c, k));
            chk(discharge == (k < DLY), "R2 discharge", discharge, (k < DLY));
            chk(uv_masked == (k >= dk), "R6 uv mask", uv_masked, (k >= dk));
            chk(done == (k >= dk), "R7 done", done, (k >= dk));
            chk($countones(sup_en & ~prev) <= 1, "R4 one per step", sup_en, prev);
            prev = sup_en;
        end
        for (int i = 0; i < NS; i++)
            if (tb_slot(c, i) == 0)
                chk(sup_en[i] == 1'b0, "R5 unused supply", sup_en[i], 0);
        chk(gate_en == '0, "R9 gates untouched", gate_en, 0);
        chk(cfg_status == 2'(c), "R10 status held", cfg_status, c);
        uv_raw = 1'b0;
        @(negedge clk);
        chk(uv_masked == 1'b0, "R6 uv follows raw", uv_masked, 0);
    endtask

    task automatic t_uv_idle();
        do_reset();
        uv_raw = 1'b1;
        @(negedge clk);
        chk(uv_masked == 1'b1, "R6 idle pass", uv_masked, 1);
        uv_raw = 1'b0;
        @(negedge clk);
        chk(uv_masked == 1'b0, "R6 idle low", uv_masked, 0);
    endtask

    task automatic t_gates();
        do_reset();
        @(negedge clk); sw_gate_wdata = 3'b101; sw_gate_we = 1'b1;
        @(negedge clk); sw_gate_we = 1'b0; sw_gate_wdata = 3'b010;
        chk(gate_en == 3'b101, "R9 write", gate_en, 5);
        pulse_start(2'd2);
        for (int k = 1; k <= DLY + 6; k++) pulse_tick();
        chk(done == 1'b1, "R7 short code done", done, 1);
        chk(gate_en == 3'b101, "R9 kept through run", gate_en, 5);
        @(negedge clk); sw_gate_wdata = 3'b010; sw_gate_we = 1'b1;
        @(negedge clk); sw_gate_we = 1'b0;
        chk(gate_en == 3'b010, "R9 rewrite", gate_en, 2);
        chk(sup_en == 6'b000011, "R5 code 2 final", sup_en, 3);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_uv_idle();
        t_sequence(0, 1'b0);
        t_sequence(1, 1'b1);
        t_sequence(2, 1'b0);
        t_sequence(3, 1'b1);
        t_gates();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule